// File: doc/BRIEF.md
# Show-Cycle External Bus Multiplexer

This block sits between a 16-bit internal bus and the external bus pins. When show cycles are on, a transfer to an internal address also appears on the pins. The strobe rises, the address and size go out, and the internal data drives the external data lines. This lets a logic analyser follow traffic that never leaves the chip.

Accesses to external addresses always go out on the pins as normal bus cycles. For a byte write to an external address, the written byte is copied onto every byte lane. This means the target can take it from whichever half it is wired to.

A two-bit mode input decides three things:
- whether show cycles happen at all;
- whether an external bus grant floats the pins;
- whether internal traffic must be held off while an external master owns the bus.

Every output is registered, so each result appears one clock after its inputs.

Top module: `showcyc_bus_mux`

## Requirements
- R1: While `rst_n` is low, every output is 0: strobe, data enable, data, size, address and halt request.
- R2: With mode 2'b00 (show cycles off), an internal-address cycle (`int_valid`=1, `int_is_ext`=0) leaves `ext_strobe` and `ext_data_oe` at 0.
- R3: With mode 2'b01, 2'b10 or 2'b11 and no effective grant, an internal-address cycle produces a show cycle. In it, `ext_strobe`=1 and `ext_data_oe`=1, and `ext_data` equals `int_data` unchanged on every lane. This includes a byte cycle, where the lane not written carries whatever the internal bus holds. `ext_size` and `ext_addr` copy the inputs.
- R4: An external-address byte write (`int_is_ext`=1, `int_rw`=0, `int_size`=2'b01) drives `int_data[7:0]` onto every byte lane of `ext_data`, with `ext_strobe`=1 and `ext_data_oe`=1.
- R5: An external-address write of any size other than 2'b01 drives `int_data` unchanged, with `ext_data_oe`=1.
- R6: An external-address read (`int_rw`=1) asserts `ext_strobe` and passes size and address, but keeps `ext_data_oe` at 0.
- R7: With `ext_grant`=1 in modes 2'b00, 2'b10 or 2'b11, `ext_strobe` and `ext_data_oe` are 0, whatever cycle is presented.
- R8: In mode 2'b01, `ext_grant` is ignored: show and external cycles drive the pins as if no grant were present.
- R9: `halt_req` is 1 exactly when mode is 2'b11 and `ext_grant` is 1.
- R10: With `int_valid`=0 and no other activity, `ext_strobe` and `ext_data_oe` are 0.
- R11: Each output reflects the inputs sampled at the previous rising clock edge. A change between edges does not appear before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_addr | input | 24 | Internal cycle address |
| int_data | input | 16 | Internal bus data |
| int_size | input | 2 | Transfer size (2'b01 = byte) |
| int_rw | input | 1 | 1 = read, 0 = write |
| int_valid | input | 1 | Internal cycle in progress |
| int_is_ext | input | 1 | Address decodes to external space |
| ext_grant | input | 1 | External master owns the bus |
| mode | input | 2 | Show-cycle mode |
| ext_addr | output | 24 | External address |
| ext_data | output | 16 | External data out |
| ext_data_oe | output | 1 | External data driver enable |
| ext_strobe | output | 1 | External data strobe |
| ext_size | output | 2 | External size lines |
| halt_req | output | 1 | Request to stall the internal bus |

## Verification
Every output passes through exactly one register. A cycle presented before a rising edge is therefore visible from just after that edge until the next one.

The bench changes inputs on the falling edge and samples 1 ns after the rising edge, so each check lands in the one cycle its result is due. For R11, the bench also samples just after driving new inputs, before the edge, and expects the previous result still in place. The grant, mode and halt cases are applied as single-cycle steps, so each step's result is read one edge later.

// File: rtl/showcyc_pkg.sv
`timescale 1ns/1ps
package showcyc_pkg;

   typedef enum logic [1:0] {
      MODE_OFF        = 2'b00,
      MODE_SHOW_NOARB = 2'b01,
      MODE_SHOW       = 2'b10,
      MODE_SHOW_HALT  = 2'b11
   } show_mode_e;

   localparam logic [1:0] SIZE_BYTE = 2'b01;

endpackage

// File: rtl/showcyc_mode_dec.sv
`timescale 1ns/1ps
module showcyc_mode_dec
   import showcyc_pkg::*;
(
   input  logic [1:0] mode,
   input  logic       ext_grant,
   output logic       show_en,
   output logic       grant_eff,
   output logic       halt
);
   show_mode_e m;

   always_comb begin
      m         = show_mode_e'(mode);
      show_en   = (m != MODE_OFF);
      grant_eff = ext_grant && (m != MODE_SHOW_NOARB);
      halt      = ext_grant && (m == MODE_SHOW_HALT);
   end
endmodule

// File: rtl/showcyc_lane_mux.sv
`timescale 1ns/1ps
module showcyc_lane_mux #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] din,
   input  logic              byte_rep,
   output logic [DATA_W-1:0] dout
);
   localparam int LANES = DATA_W / 8;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      if (g == 0) begin : g_low
         assign dout[7:0] = din[7:0];
      end else begin : g_up
         assign dout[g*8 +: 8] = byte_rep ? din[7:0] : din[g*8 +: 8];
      end
   end
endmodule

// File: rtl/showcyc_out_stage.sv
`timescale 1ns/1ps
module showcyc_out_stage #(
   parameter int W       = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk;
      assign q = rst_n ? d : '0;
   end
endmodule

// File: rtl/showcyc_bus_mux.sv
`timescale 1ns/1ps
module showcyc_bus_mux
   import showcyc_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int DATA_W  = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] int_addr,
   input  logic [DATA_W-1:0] int_data,
   input  logic [1:0]        int_size,
   input  logic              int_rw,
   input  logic              int_valid,
   input  logic              int_is_ext,
   input  logic              ext_grant,
   input  logic [1:0]        mode,
   output logic [ADDR_W-1:0] ext_addr,
   output logic [DATA_W-1:0] ext_data,
   output logic              ext_data_oe,
   output logic              ext_strobe,
   output logic [1:0]        ext_size,
   output logic              halt_req
);
   localparam int OUT_W = ADDR_W + DATA_W + 2 + 3;

   if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_data_w
      $error("showcyc_bus_mux: DATA_W must be a multiple of 8, at least 16");
   end
   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("showcyc_bus_mux: ADDR_W must be positive");
   end

   logic show_en, grant_eff, halt;
   logic byte_rep;
   logic [DATA_W-1:0] lane_data;

   showcyc_mode_dec i_dec (
      .mode      (mode),
      .ext_grant (ext_grant),
      .show_en   (show_en),
      .grant_eff (grant_eff),
      .halt      (halt)
   );

   assign byte_rep = int_is_ext && !int_rw && (int_size == SIZE_BYTE);

   showcyc_lane_mux #(.DATA_W(DATA_W)) i_lanes (
      .din      (int_data),
      .byte_rep (byte_rep),
      .dout     (lane_data)
   );

   logic [ADDR_W-1:0] n_addr;
   logic [DATA_W-1:0] n_data;
   logic              n_oe, n_strobe;
   logic [1:0]        n_size;

   always_comb begin
      n_addr   = '0;
      n_data   = '0;
      n_oe     = 1'b0;
      n_strobe = 1'b0;
      n_size   = '0;
      if (int_valid && !grant_eff) begin
         if (int_is_ext) begin
            n_strobe = 1'b1;
            n_addr   = int_addr;
            n_size   = int_size;
            if (!int_rw) begin
               n_oe   = 1'b1;
               n_data = lane_data;
            end
         end else if (show_en) begin
            n_strobe = 1'b1;
            n_oe     = 1'b1;
            n_addr   = int_addr;
            n_size   = int_size;
            n_data   = lane_data;
         end
      end
   end

   logic [OUT_W-1:0] stage_d, stage_q;
   assign stage_d = {n_addr, n_data, n_size, n_oe, n_strobe, halt};

   showcyc_out_stage #(.W(OUT_W), .REG_OUT(REG_OUT)) i_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (stage_d),
      .q     (stage_q)
   );

   assign {ext_addr, ext_data, ext_size, ext_data_oe, ext_strobe, halt_req} = stage_q;

   if (REG_OUT) begin : g_chk
      assert_halt_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
         halt_req == $past(mode == 2'b11 && ext_grant));

      assert_granted_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $past(ext_grant && mode != 2'b01) |-> (!ext_strobe && !ext_data_oe));

      assert_noshow_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
         ext_strobe |-> $past(int_valid && (int_is_ext || mode != 2'b00)));

      assert_oe_write_or_show_R6: assert property (@(posedge clk) disable iff (!rst_n)
         ext_data_oe |-> $past(int_valid && (!int_rw || !int_is_ext)));

      assert_byte_replicated_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (ext_data_oe && $past(int_is_ext && !int_rw && int_size == 2'b01))
         |-> (ext_data[15:8] == $past(int_data[7:0]) && ext_data[7:0] == $past(int_data[7:0])));

      assert_noarb_drives_R8: assert property (@(posedge clk) disable iff (!rst_n)
         $past(mode == 2'b01 && int_valid && !int_is_ext) |-> (ext_strobe && ext_data_oe));
   end
endmodule

// File: tb/test_showcyc_bus_mux.sv
`timescale 1ns/1ps
module test_showcyc_bus_mux;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] int_addr = '0;
   logic [15:0] int_data = '0;
   logic [1:0]  int_size = '0;
   logic        int_rw = 1'b1;
   logic        int_valid = 1'b0;
   logic        int_is_ext = 1'b0;
   logic        ext_grant = 1'b0;
   logic [1:0]  mode = '0;
   logic [23:0] ext_addr;
   logic [15:0] ext_data;
   logic        ext_data_oe, ext_strobe, halt_req;
   logic [1:0]  ext_size;

   int nvec = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   showcyc_bus_mux i_showcyc_bus_mux (
      .clk(clk), .rst_n(rst_n), .int_addr(int_addr), .int_data(int_data),
      .int_size(int_size), .int_rw(int_rw), .int_valid(int_valid),
      .int_is_ext(int_is_ext), .ext_grant(ext_grant), .mode(mode),
      .ext_addr(ext_addr), .ext_data(ext_data), .ext_data_oe(ext_data_oe),
      .ext_strobe(ext_strobe), .ext_size(ext_size), .halt_req(halt_req)
   );

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic drive(logic [1:0] m, logic g, logic v, logic ext, logic rw,
                        logic [1:0] sz, logic [23:0] a, logic [15:0] d);
      @(negedge clk);
      mode = m; ext_grant = g; int_valid = v; int_is_ext = ext;
      int_rw = rw; int_size = sz; int_addr = a; int_data = d;
   endtask

   task automatic settle();
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      #1;
      check("R1", "strobe", 32'(ext_strobe), 0);
      check("R1", "oe", 32'(ext_data_oe), 0);
      check("R1", "data", 32'(ext_data), 0);
      check("R1", "halt", 32'(halt_req), 0);
      check("R1", "addr", 32'(ext_addr), 0);
      check("R1", "size", 32'(ext_size), 0);
   endtask

   task automatic t_mode_off();
      drive(2'b00, 0, 1, 0, 0, 2'b10, 24'h000100, 16'h1111);
      settle();
      check("R2", "strobe", 32'(ext_strobe), 0);
      check("R2", "oe", 32'(ext_data_oe), 0);
   endtask

   task automatic t_show_word();
      drive(2'b10, 0, 1, 0, 1, 2'b10, 24'h00ABCD, 16'hA5C3);
      settle();
      check("R3", "strobe", 32'(ext_strobe), 1);
      check("R3", "oe", 32'(ext_data_oe), 1);
      check("R3", "data", 32'(ext_data), 32'h A5C3);
      check("R3", "size", 32'(ext_size), 2);
      check("R3", "addr", 32'(ext_addr), 32'h00ABCD);
   endtask

   task automatic t_show_byte();
      drive(2'b11, 0, 1, 0, 0, 2'b01, 24'h000201, 16'h1234);
      settle();
      check("R3", "byte show data", 32'(ext_data), 32'h1234);
      check("R3", "byte show size", 32'(ext_size), 1);
   endtask

   task automatic t_ext_byte();
      drive(2'b00, 0, 1, 1, 0, 2'b01, 24'h400003, 16'hBE7A);
      settle();
      check("R4", "data", 32'(ext_data), 32'h7A7A);
      check("R4", "oe", 32'(ext_data_oe), 1);
      check("R4", "strobe", 32'(ext_strobe), 1);
   endtask

   task automatic t_ext_word();
      drive(2'b10, 0, 1, 1, 0, 2'b10, 24'h400004, 16'hBE7A);
      settle();
      check("R5", "data", 32'(ext_data), 32'hBE7A);
      check("R5", "oe", 32'(ext_data_oe), 1);
   endtask

   task automatic t_ext_read();
      drive(2'b10, 0, 1, 1, 1, 2'b01, 24'h400010, 16'h5555);
      settle();
      check("R6", "strobe", 32'(ext_strobe), 1);
      check("R6", "oe", 32'(ext_data_oe), 0);
      check("R6", "size", 32'(ext_size), 1);
      check("R6", "addr", 32'(ext_addr), 32'h400010);
   endtask

   task automatic t_grant();
      drive(2'b10, 1, 1, 0, 0, 2'b10, 24'h000300, 16'hCAFE);
      settle();
      check("R7", "mode2 strobe", 32'(ext_strobe), 0);
      check("R7", "mode2 oe", 32'(ext_data_oe), 0);
      check("R9", "mode2 halt", 32'(halt_req), 0);
      drive(2'b11, 1, 1, 0, 0, 2'b10, 24'h000300, 16'hCAFE);
      settle();
      check("R7", "mode3 oe", 32'(ext_data_oe), 0);
      check("R9", "mode3 halt", 32'(halt_req), 1);
      drive(2'b00, 1, 1, 1, 0, 2'b10, 24'h400300, 16'hCAFE);
      settle();
      check("R7", "mode0 ext strobe", 32'(ext_strobe), 0);
      check("R9", "mode0 halt", 32'(halt_req), 0);
      drive(2'b11, 0, 0, 0, 1, 2'b00, 24'h0, 16'h0);
      settle();
      check("R9", "mode3 no grant halt", 32'(halt_req), 0);
   endtask

   task automatic t_noarb();
      drive(2'b01, 1, 1, 0, 1, 2'b10, 24'h000500, 16'h0F0F);
      settle();
      check("R8", "strobe", 32'(ext_strobe), 1);
      check("R8", "oe", 32'(ext_data_oe), 1);
      check("R8", "data", 32'(ext_data), 32'h0F0F);
      check("R9", "mode1 halt", 32'(halt_req), 0);
      drive(2'b01, 1, 1, 1, 0, 2'b01, 24'h400500, 16'h00C4);
      settle();
      check("R8", "ext byte data", 32'(ext_data), 32'hC4C4);
   endtask

   task automatic t_idle();
      drive(2'b10, 0, 0, 0, 0, 2'b10, 24'h000600, 16'h9999);
      settle();
      check("R10", "strobe", 32'(ext_strobe), 0);
      check("R10", "oe", 32'(ext_data_oe), 0);
   endtask

   task automatic t_latency();
      drive(2'b10, 0, 1, 0, 1, 2'b10, 24'h000700, 16'h7777);
      settle();
      drive(2'b10, 0, 1, 0, 1, 2'b10, 24'h000704, 16'h8888);
      #1;
      check("R11", "before edge data", 32'(ext_data), 32'h7777);
      check("R11", "before edge addr", 32'(ext_addr), 32'h000700);
      settle();
      check("R11", "after edge data", 32'(ext_data), 32'h8888);
   endtask

   initial begin
      t_reset();
      #12;
      @(negedge clk);
      rst_n = 1'b1;
      t_mode_off();
      t_show_word();
      t_show_byte();
      t_ext_byte();
      t_ext_word();
      t_ext_read();
      t_grant();
      t_noarb();
      t_idle();
      t_latency();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1'b1;
         nfail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end
endmodule